// File: doc/BRIEF.md
# Coherence Snoop Responder for a Write-Back Data Cache

This block sits beside a local write-back data cache and watches every address tenure on a shared system bus. Each snooped tenure carries a transaction kind, a coherence qualifier and a byte address. The block looks up the tag and MESI state held for that address in its own direct-mapped tag/state array. It then drives a registered shared response and a registered retry response, rewrites the coherence state of the line, and, when another master wants to own a line that holds dirty data, raises a request to push that line back to memory.

The local cache controller installs lines through a fill port. It reads the coherence state of any address through a combinational lookup port. The data array, bus arbitration and the data transfer of a push are outside this block. Only the push request and its acknowledge are handled here. While a push is outstanding, every coherent snoop is told to retry.

Top module: `coh_snoop_ctl`

## Requirements
- R1: A snoop with `snp_valid` low or `snp_coherent` low produces no shared or retry response, starts no push and changes no line state.
- R2: A read (kind 0) or atomic read (kind 1) that misses, or that finds the line in I (state code 0), gives no response. A hit in S (code 1) gives the shared response only, and the line stays S.
- R3: A read or atomic read that hits a line in E (code 2) gives the shared response only and moves the line to S.
- R4: A read or atomic read that hits a line in M (code 3) gives both the shared and the retry responses, moves the line to S and starts no push.
- R5: A read-for-ownership (kind 2) or atomic read-for-ownership (kind 3) that misses does nothing. A hit in S or E moves the line to I with no response.
- R6: A read-for-ownership or its atomic form that hits a line in M gives both responses, moves the line to I and raises `push_req`. `push_addr` carries the snooped address with its line-offset bits cleared.
- R7: A block invalidate (kind 4) or write-with-invalidate (kind 5) that hits a valid line moves it to I, with no response and no push. Kinds 6 and 7 have no effect.
- R8: `shared_o` and `retry_o` are high only in the single cycle after the clock edge that samples the snoop.
- R9: `push_req` stays high, with `push_addr` unchanged, until a clock edge at which `push_ack` is high. It is low from the following cycle.
- R10: A coherent snoop sampled while `push_req` is high gets the retry response without the shared response. It changes no line state and starts no new push.
- R11: A `fill_en` edge writes the tag and state of `fill_addr`. A snoop state change to the same set at the same edge takes priority over the fill. `lkp_state` shows the state of `lkp_addr` when its tag matches, and I otherwise.
- R12: Synchronous reset sets every line to I and drives `shared_o`, `retry_o` and `push_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_valid | input | 1 | Address tenure present this cycle |
| snp_kind | input | 3 | Transaction kind code (0..7) |
| snp_coherent | input | 1 | Coherence qualifier; snoop acts only when high |
| snp_addr | input | ADDR_W | Snooped byte address |
| shared_o | output | 1 | Registered shared response |
| retry_o | output | 1 | Registered retry response |
| push_req | output | 1 | Request to write a modified line back |
| push_addr | output | ADDR_W | Line-aligned address of the line to push |
| push_ack | input | 1 | Push accepted by the data mover |
| fill_en | input | 1 | Install a line from the local side |
| fill_addr | input | ADDR_W | Address of the line being installed |
| fill_state | input | 2 | State of the installed line (I=0, S=1, E=2, M=3) |
| lkp_addr | input | ADDR_W | Local lookup address |
| lkp_state | output | 2 | State held for `lkp_addr`, I on tag mismatch |

## Verification
The assertions assume that a tenure's kind, qualifier and address are sampled only at the edge where `snp_valid` is high. They also assume that `push_ack` arrives while `push_req` is high, or is harmlessly ignored when it is not. The bench holds every input steady between edges by driving it shortly after a rising edge. It drives `push_ack` freely, including in cycles with no push pending, to show that a stray acknowledge does nothing. A fill and a snoop to the same set at one edge are driven on purpose, so the bench sees which update wins.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef enum logic [2:0] {
        SN_RD        = 3'd0,
        SN_RD_ATOM   = 3'd1,
        SN_RDX       = 3'd2,
        SN_RDX_ATOM  = 3'd3,
        SN_INV       = 3'd4,
        SN_WR_INV    = 3'd5,
        SN_RSV6      = 3'd6,
        SN_RSV7      = 3'd7
    } snp_kind_e;

    typedef struct packed {
        logic  shared;
        logic  retry;
        logic  push;
        logic  upd;
        mesi_e nstate;
    } snp_resp_t;

    // Decide the reaction to one sampled snoop.
    function automatic snp_resp_t snoop_decide(
        input logic      act,
        input logic      pending,
        input logic      hit,
        input mesi_e     cur,
        input snp_kind_e kind
    );
        snp_resp_t r;
        r = '0;
        r.nstate = cur;
        if (act) begin
            if (pending) begin
                r.retry = 1'b1;
            end else if (hit) begin
                case (kind)
                    SN_RD, SN_RD_ATOM: begin
                        r.shared = 1'b1;
                        r.retry  = (cur == ST_M);
                        if (cur != ST_S) begin
                            r.upd    = 1'b1;
                            r.nstate = ST_S;
                        end
                    end
                    SN_RDX, SN_RDX_ATOM: begin
                        r.upd    = 1'b1;
                        r.nstate = ST_I;
                        if (cur == ST_M) begin
                            r.shared = 1'b1;
                            r.retry  = 1'b1;
                            r.push   = 1'b1;
                        end
                    end
                    SN_INV, SN_WR_INV: begin
                        r.upd    = 1'b1;
                        r.nstate = ST_I;
                    end
                    default: r.upd = 1'b0;
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/coh_tag_array.sv
module coh_tag_array
    import coh_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [TAG_W-1:0] a_tag,
    output logic             a_hit,
    output mesi_e            a_state,
    input  logic [IDX_W-1:0] b_idx,
    input  logic [TAG_W-1:0] b_tag,
    output mesi_e            b_state,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  mesi_e            fill_state,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  mesi_e            upd_state
);

    logic [TAG_W-1:0] tag_q [SETS];
    mesi_e            st_q  [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SETS; i++) begin
                st_q[i]  <= ST_I;
                tag_q[i] <= '0;
            end
        end else begin
            if (fill_en) begin
                st_q[fill_idx]  <= fill_state;
                tag_q[fill_idx] <= fill_tag;
            end
            // snoop update is written last so it wins on a shared set
            if (upd_en) begin
                st_q[upd_idx] <= upd_state;
            end
        end
    end

    assign a_state = st_q[a_idx];
    assign a_hit   = (st_q[a_idx] != ST_I) && (tag_q[a_idx] == a_tag);
    assign b_state = ((st_q[b_idx] != ST_I) && (tag_q[b_idx] == b_tag)) ? st_q[b_idx] : ST_I;

    // R11
    snoop_wins_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> st_q[$past(upd_idx)] == $past(upd_state));

    // R11
    fill_write_chk: assert property (@(posedge clk) disable iff (rst)
        fill_en && !(upd_en && upd_idx == fill_idx)
        |=> st_q[$past(fill_idx)] == $past(fill_state) && tag_q[$past(fill_idx)] == $past(fill_tag));

endmodule

// File: rtl/coh_push_ctl.sv
module coh_push_ctl #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              ack,
    output logic              req,
    output logic [ADDR_W-1:0] addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req  <= 1'b0;
            addr <= '0;
        end else if (start) begin
            req  <= 1'b1;
            addr <= start_addr;
        end else if (req && ack) begin
            req <= 1'b0;
        end
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req && !ack |=> req);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req && !ack |=> $stable(addr));

    // R9
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        req && ack && !start |=> !req);

endmodule

// File: rtl/coh_snoop_ctl.sv
module coh_snoop_ctl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int SETS   = 8,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  logic [2:0]        snp_kind,
    input  logic              snp_coherent,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              shared_o,
    output logic              retry_o,
    output logic              push_req,
    output logic [ADDR_W-1:0] push_addr,
    input  logic              push_ack,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [1:0]        fill_state,
    input  logic [ADDR_W-1:0] lkp_addr,
    output logic [1:0]        lkp_state
);

    logic       snp_hit;
    mesi_e      snp_state;
    mesi_e      lkp_st;
    snp_resp_t  resp;
    logic [ADDR_W-1:0] line_addr;

    coh_tag_array #(
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) i_tags (
        .clk        (clk),
        .rst        (rst),
        .a_idx      (snp_addr[OFF_W +: IDX_W]),
        .a_tag      (snp_addr[ADDR_W-1 -: TAG_W]),
        .a_hit      (snp_hit),
        .a_state    (snp_state),
        .b_idx      (lkp_addr[OFF_W +: IDX_W]),
        .b_tag      (lkp_addr[ADDR_W-1 -: TAG_W]),
        .b_state    (lkp_st),
        .fill_en    (fill_en),
        .fill_idx   (fill_addr[OFF_W +: IDX_W]),
        .fill_tag   (fill_addr[ADDR_W-1 -: TAG_W]),
        .fill_state (mesi_e'(fill_state)),
        .upd_en     (resp.upd),
        .upd_idx    (snp_addr[OFF_W +: IDX_W]),
        .upd_state  (resp.nstate)
    );

    always_comb begin
        resp = snoop_decide(snp_valid && snp_coherent, push_req, snp_hit,
                            snp_state, snp_kind_e'(snp_kind));
    end

    assign line_addr = {snp_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign lkp_state = lkp_st;

    always_ff @(posedge clk) begin
        if (rst) begin
            shared_o <= 1'b0;
            retry_o  <= 1'b0;
        end else begin
            shared_o <= resp.shared;
            retry_o  <= resp.retry;
        end
    end

    coh_push_ctl #(
        .ADDR_W (ADDR_W)
    ) i_push (
        .clk        (clk),
        .rst        (rst),
        .start      (resp.push),
        .start_addr (line_addr),
        .ack        (push_ack),
        .req        (push_req),
        .addr       (push_addr)
    );

    // R8
    resp_window_chk: assert property (@(posedge clk) disable iff (rst)
        (shared_o || retry_o) |-> $past(snp_valid && snp_coherent));

    // R1
    ignore_noncoh_chk: assert property (@(posedge clk) disable iff (rst)
        snp_valid && !snp_coherent |=> !shared_o && !retry_o);

    // R10
    busy_retry_chk: assert property (@(posedge clk) disable iff (rst)
        snp_valid && snp_coherent && push_req |=> retry_o && !shared_o);

    // R6
    push_with_resp_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(push_req) |-> retry_o && shared_o);

endmodule

// File: tb/test_coh_snoop_ctl.sv
module test_coh_snoop_ctl;

    localparam int ADDR_W = 32;
    localparam int OFF_W  = 5;
    localparam int SETS   = 8;
    localparam int IDX_W  = 3;
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              snp_valid = 1'b0;
    logic [2:0]        snp_kind = 3'd0;
    logic              snp_coherent = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              shared_o, retry_o, push_req;
    logic [ADDR_W-1:0] push_addr;
    logic              push_ack = 1'b0;
    logic              fill_en = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [1:0]        fill_state = 2'd0;
    logic [ADDR_W-1:0] lkp_addr = '0;
    logic [1:0]        lkp_state;

    always #4 clk = ~clk;

    coh_snoop_ctl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(SETS)) i_coh_snoop_ctl (
        .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_kind(snp_kind),
        .snp_coherent(snp_coherent), .snp_addr(snp_addr), .shared_o(shared_o),
        .retry_o(retry_o), .push_req(push_req), .push_addr(push_addr),
        .push_ack(push_ack), .fill_en(fill_en), .fill_addr(fill_addr),
        .fill_state(fill_state), .lkp_addr(lkp_addr), .lkp_state(lkp_state)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R12";
    bit    started = 1'b0;

    // behavioural reference model
    logic [TAG_W-1:0]  m_tag [SETS];
    int                m_st  [SETS];
    bit                m_pend;
    logic [ADDR_W-1:0] m_paddr;
    bit                e_sh, e_rt;

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx, input int off);
        mk = (ADDR_W'(tag) << (OFF_W + IDX_W)) | (ADDR_W'(idx) << OFF_W) | ADDR_W'(off);
    endfunction

    function automatic int mlook(input logic [ADDR_W-1:0] a);
        int ix;
        ix = int'(a[OFF_W +: IDX_W]);
        if (m_st[ix] != 0 && m_tag[ix] == a[ADDR_W-1 -: TAG_W]) return m_st[ix];
        return 0;
    endfunction

    always @(posedge clk) begin
        int ix, st, nst;
        bit act, hit, upd, push;
        started = 1'b1;
        if (rst) begin
            for (int i = 0; i < SETS; i++) begin m_st[i] = 0; m_tag[i] = '0; end
            m_pend = 0; m_paddr = '0; e_sh = 0; e_rt = 0;
        end else begin
            act = snp_valid && snp_coherent;
            ix  = int'(snp_addr[OFF_W +: IDX_W]);
            st  = m_st[ix];
            hit = (st != 0) && (m_tag[ix] == snp_addr[ADDR_W-1 -: TAG_W]);
            e_sh = 0; e_rt = 0; upd = 0; push = 0; nst = st;
            if (act && m_pend) e_rt = 1;
            else if (act && hit) begin
                if (snp_kind <= 3'd1) begin
                    e_sh = 1; e_rt = (st == 3); nst = 1; upd = 1;
                end else if (snp_kind <= 3'd3) begin
                    nst = 0; upd = 1;
                    if (st == 3) begin e_sh = 1; e_rt = 1; push = 1; end
                end else if (snp_kind <= 3'd5) begin
                    nst = 0; upd = 1;
                end
            end
            if (m_pend && push_ack) m_pend = 0;
            if (push) begin
                m_pend = 1;
                m_paddr = {snp_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            end
            if (fill_en) begin
                m_st[int'(fill_addr[OFF_W +: IDX_W])]  = int'(fill_state);
                m_tag[int'(fill_addr[OFF_W +: IDX_W])] = fill_addr[ADDR_W-1 -: TAG_W];
            end
            if (upd) m_st[ix] = nst;
        end
    end

    task automatic check(input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            check("shared_o", int'(shared_o), int'(e_sh));
            check("retry_o", int'(retry_o), int'(e_rt));
            check("push_req", int'(push_req), int'(m_pend));
            if (m_pend) check("push_addr", int'(push_addr), int'(m_paddr));
            check("lkp_state", int'(lkp_state), mlook(lkp_addr));
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
        snp_valid = 1'b0;
        fill_en   = 1'b0;
    endtask

    task automatic fill(input logic [ADDR_W-1:0] a, input int st);
        fill_en = 1'b1; fill_addr = a; fill_state = 2'(st); lkp_addr = a;
        tick();
    endtask

    task automatic snoop(input int kind, input bit coh, input logic [ADDR_W-1:0] a);
        snp_valid = 1'b1; snp_kind = 3'(kind); snp_coherent = coh; snp_addr = a;
        lkp_addr = a;
        tick();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        // R12: reset state
        cur_req = "R12";
        repeat (3) @(posedge clk);
        #2; rst = 1'b0;
        tick();

        // R11: installs via fill port
        cur_req = "R11";
        fill(mk(5, 0, 0), 1);
        fill(mk(5, 1, 0), 2);
        fill(mk(5, 2, 0), 3);
        fill(mk(5, 3, 0), 3);
        lkp_addr = mk(6, 2, 0);  // tag mismatch reads I
        tick();

        // R1: non-coherent and non-valid snoops ignored
        cur_req = "R1";
        snoop(2, 1'b0, mk(5, 2, 0));
        snoop(0, 1'b0, mk(5, 1, 0));
        snp_kind = 3'd4; snp_coherent = 1'b1; snp_addr = mk(5, 3, 0); lkp_addr = mk(5, 3, 0);
        tick();

        // R2: read hit S, read miss
        cur_req = "R2";
        snoop(0, 1'b1, mk(5, 0, 4));
        snoop(1, 1'b1, mk(9, 0, 0));
        snoop(0, 1'b1, mk(5, 7, 0));

        // R3: read hit E
        cur_req = "R3";
        snoop(0, 1'b1, mk(5, 1, 8));
        snoop(1, 1'b1, mk(5, 1, 8));

        // R4: atomic read hit M
        cur_req = "R4";
        snoop(1, 1'b1, mk(5, 2, 0));
        tick();

        // R5: read-for-ownership on S, E, miss
        cur_req = "R5";
        fill(mk(7, 4, 0), 1);
        fill(mk(7, 5, 0), 2);
        snoop(2, 1'b1, mk(7, 4, 0));
        snoop(3, 1'b1, mk(7, 5, 0));
        snoop(2, 1'b1, mk(8, 6, 0));

        // R6: read-for-ownership on M raises push
        cur_req = "R6";
        snoop(2, 1'b1, mk(5, 3, 12));
        // R10: snoops while push pending get retry only
        cur_req = "R10";
        fill(mk(5, 6, 0), 3);
        snoop(0, 1'b1, mk(5, 6, 0));
        snoop(3, 1'b1, mk(5, 6, 0));
        // R9: request held, then dropped on ack
        cur_req = "R9";
        repeat (3) tick();
        push_ack = 1'b1;
        tick();
        push_ack = 1'b0;
        tick();
        push_ack = 1'b1;  // stray acknowledge has no effect
        tick();
        push_ack = 1'b0;

        // R7: invalidate kinds and reserved kinds
        cur_req = "R7";
        fill(mk(3, 7, 0), 2);
        snoop(6, 1'b1, mk(5, 6, 0));
        snoop(7, 1'b1, mk(3, 7, 0));
        snoop(4, 1'b1, mk(5, 6, 0));
        snoop(5, 1'b1, mk(3, 7, 0));

        // R11: snoop update beats fill on the same set
        cur_req = "R11";
        fill(mk(2, 4, 0), 3);
        fill_en = 1'b1; fill_addr = mk(2, 4, 0); fill_state = 2'd2;
        snoop(4, 1'b1, mk(2, 4, 0));
        tick();

        // R8: mixed traffic, one-cycle response window
        cur_req = "R8";
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 3) == 0) begin
                fill_en = 1'b1;
                fill_addr = mk($urandom_range(0, 1), $urandom_range(0, 7), 0);
                fill_state = 2'($urandom_range(0, 3));
            end
            push_ack = ($urandom_range(0, 3) == 0);
            snp_valid = ($urandom_range(0, 2) != 0);
            snp_kind = 3'($urandom_range(0, 7));
            snp_coherent = ($urandom_range(0, 5) != 0);
            snp_addr = mk($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 31));
            lkp_addr = mk($urandom_range(0, 1), $urandom_range(0, 7), 0);
            tick();
        end
        push_ack = 1'b0;
        tick();

        // R12: reset clears lines and outputs
        cur_req = "R12";
        fill(mk(1, 1, 0), 3);
        snoop(2, 1'b1, mk(1, 1, 0));
        rst = 1'b1;
        tick();
        rst = 1'b0;
        lkp_addr = mk(1, 1, 0);
        tick();
        tick();
        finish_run();
    end

endmodule